// File: doc/BRIEF.md
# Sixteen-Channel Linked-Loop DMA Controller

This block moves 32-bit words between memory locations on behalf of sixteen independent channels. Each channel owns a descriptor holding a source address, a destination address, a per-activation byte count, an outer iteration count, signed per-access address steps, signed end-of-transfer address corrections, two optional link targets and a completion interrupt enable. Descriptors are loaded through a narrow register write port. Every word is moved by a read from the source followed by a write to the destination, over a single-beat request/ready memory port with one access outstanding.

A transfer is organised as two nested loops. One activation of a channel runs exactly one inner loop, which moves the programmed number of bytes. The outer count says how many inner loops make up the whole transfer. A channel is activated either by a pulse on its software start input or by a link from another channel. A link can fire at the end of an inner loop that is not the last, or at the end of the whole transfer, and each of these has its own target. This lets chains of channels run without software. When a transfer completes, the channel's addresses are corrected and its outer count is reloaded, so the descriptor can be used again. Its done flag is set, and an interrupt is raised if the channel has that enabled.

Pending activations are held in a request register. Between inner loops, an arbiter chooses the next channel by fixed priority or by round-robin, depending on a mode input. The engine is one state machine with five states:

- ST_IDLE waits for a grant and moves to ST_LOAD on one.
- ST_LOAD copies the descriptor into working registers. It moves to ST_READ, or straight to ST_FINISH when the word count is zero.
- ST_READ holds a read request until ready, then moves to ST_WRITE.
- ST_WRITE holds a write request until ready. It returns to ST_READ while words remain and otherwise moves to ST_FINISH.
- ST_FINISH writes the updated addresses and count back to the descriptor, fires any link, sets the done flag if this was the last inner loop, and returns to ST_IDLE.

Top module: `lld_dma`

## Requirements
- R1: After reset, mem_req is low and every done and irq bit is zero.
- R2: Each word is moved by an accepted read at the current source address, followed by an accepted write of the same data to the current destination address.
- R3: One activation moves floor(N/4) words, where N is field 2 bits [15:0]. When that count is zero, the activation makes no memory access but still counts as a completed inner loop.
- R4: After each accepted read, the source address moves by the signed 16-bit step in field 4 bits [15:0]. After each accepted write, the destination address moves by the signed step in field 4 bits [31:16]. The addresses carry over between activations.
- R5: Field 3 bits [15:0] set the outer count. Each activation runs one inner loop, and the transfer completes on the activation that finds the count at 1 (a count of 0 behaves as 1).
- R6: When a transfer completes, the source address is adjusted by the signed 32-bit value in field 5 and the destination address by the signed value in field 6, and the outer count is reloaded, so a later start repeats the transfer.
- R7: A pulse on start[c] requests an activation of channel c and clears done[c].
- R8: If field 7 bit 1 is set, the end of an inner loop that is not the last requests the channel given by field 7 bits [7:4].
- R9: If field 7 bit 8 is set, the end of the last inner loop requests the channel given by field 7 bits [15:12].
- R10: With rr_mode low, the lowest-numbered pending channel is served first.
- R11: With rr_mode high, the search for the next channel starts at the channel after the last one served, wrapping from 15 to 0.
- R12: A running inner loop is never interrupted by another channel. A request to a channel that is already pending is merged into the existing request.
- R13: done[c] is set when channel c completes its transfer, and irq[c] equals done[c] AND field 7 bit 0 of channel c.
- R14: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_ch | input | 4 | Channel whose descriptor is written |
| cfg_sel | input | 3 | Field: 0 source, 1 destination, 2 byte count, 3 outer count, 4 steps, 5 source correction, 6 destination correction, 7 control |
| cfg_wdata | input | 32 | Field write data |
| start | input | 16 | Software start pulses, one per channel |
| rr_mode | input | 1 | 0 fixed priority, 1 round-robin |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| done | output | 16 | Per-channel transfer-complete flags |
| irq | output | 16 | Per-channel interrupt requests |

## Verification
The copy function is tried with four patterns. Unit steps with a multi-word count confirm the read/write alternation and the data. A stride of eight on the source with a negative destination step tells real offset arithmetic apart from a fixed increment. A zero count checks that the inner loop can complete with no memory access. A stalled ready that is high only one cycle in three shows that requests are held and that the data still lands correctly. Arbitration is tried by starting three channels in the same cycle under each mode: 4, 9, 12 distinguishes fixed order from the rotated order 12, 4, 9. A long inner loop with repeated starts to a higher-priority channel separates non-preemption and merging from queuing. The outer-count and link runs start the same channels repeatedly and count the writes per region, which separates minor-end links from major-end links and shows the address correction on reuse.

// File: rtl/lld_pkg.sv
package lld_pkg;

    localparam int CH_W   = 4;
    localparam int NUM_CH = 1 << CH_W;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int OFF_W  = 16;
    localparam int WRD_W  = CNT_W - 2;

    // descriptor field selectors on the register port
    localparam logic [2:0] FLD_SRC   = 3'd0;
    localparam logic [2:0] FLD_DST   = 3'd1;
    localparam logic [2:0] FLD_BYTES = 3'd2;
    localparam logic [2:0] FLD_MAJOR = 3'd3;
    localparam logic [2:0] FLD_STEP  = 3'd4;
    localparam logic [2:0] FLD_SCORR = 3'd5;
    localparam logic [2:0] FLD_DCORR = 3'd6;
    localparam logic [2:0] FLD_CTRL  = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } eng_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] saddr;
        logic [ADDR_W-1:0] daddr;
        logic [WRD_W-1:0]  nwords;
        logic [CNT_W-1:0]  citer;
        logic [CNT_W-1:0]  biter;
        logic [OFF_W-1:0]  sstep;
        logic [OFF_W-1:0]  dstep;
        logic [ADDR_W-1:0] scorr;
        logic [ADDR_W-1:0] dcorr;
        logic              mlink_en;
        logic [CH_W-1:0]   mlink_ch;
        logic              elink_en;
        logic [CH_W-1:0]   elink_ch;
    } desc_t;

    function automatic logic [ADDR_W-1:0] sext_step(input logic [OFF_W-1:0] v);
        return {{(ADDR_W-OFF_W){v[OFF_W-1]}}, v};
    endfunction

endpackage

// File: rtl/lld_desc_bank.sv
module lld_desc_bank
    import lld_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [CH_W-1:0]   rd_ch,
    output desc_t             rd_desc,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_saddr,
    input  logic [ADDR_W-1:0] wb_daddr,
    input  logic [CNT_W-1:0]  wb_citer,
    input  logic              done_set,
    input  logic [NCH-1:0]    start,
    output logic [NCH-1:0]    done,
    output logic [NCH-1:0]    irq
);

    desc_t          tbl [NCH];
    logic [NCH-1:0] ien_q;
    logic [NCH-1:0] done_q;
    logic [NCH-1:0] set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                tbl[i] <= '0;
            end
            ien_q <= '0;
        end else begin
            if (wb_en) begin
                tbl[rd_ch].saddr <= wb_saddr;
                tbl[rd_ch].daddr <= wb_daddr;
                tbl[rd_ch].citer <= wb_citer;
            end
            if (cfg_we) begin
                unique case (cfg_sel)
                    FLD_SRC:   tbl[cfg_ch].saddr  <= cfg_wdata[ADDR_W-1:0];
                    FLD_DST:   tbl[cfg_ch].daddr  <= cfg_wdata[ADDR_W-1:0];
                    FLD_BYTES: tbl[cfg_ch].nwords <= cfg_wdata[CNT_W-1:2];
                    FLD_MAJOR: begin
                        tbl[cfg_ch].citer <= cfg_wdata[CNT_W-1:0];
                        tbl[cfg_ch].biter <= cfg_wdata[CNT_W-1:0];
                    end
                    FLD_STEP: begin
                        tbl[cfg_ch].sstep <= cfg_wdata[OFF_W-1:0];
                        tbl[cfg_ch].dstep <= cfg_wdata[2*OFF_W-1:OFF_W];
                    end
                    FLD_SCORR: tbl[cfg_ch].scorr <= cfg_wdata[ADDR_W-1:0];
                    FLD_DCORR: tbl[cfg_ch].dcorr <= cfg_wdata[ADDR_W-1:0];
                    FLD_CTRL: begin
                        ien_q[cfg_ch]        <= cfg_wdata[0];
                        tbl[cfg_ch].mlink_en <= cfg_wdata[1];
                        tbl[cfg_ch].mlink_ch <= cfg_wdata[4 +: CH_W];
                        tbl[cfg_ch].elink_en <= cfg_wdata[8];
                        tbl[cfg_ch].elink_ch <= cfg_wdata[12 +: CH_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_desc = tbl[rd_ch];

    always_comb begin
        set_vec = '0;
        if (done_set) begin
            set_vec[rd_ch] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            done_q <= (done_q & ~start) | set_vec;
        end
    end

    assign done = done_q;
    assign irq  = done_q & ien_q;

endmodule

// File: rtl/lld_arbiter.sv
module lld_arbiter
    import lld_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  start,
    input  logic            link_valid,
    input  logic [CH_W-1:0] link_ch,
    input  logic            rr_mode,
    input  logic            take,
    output logic            gnt_valid,
    output logic [CH_W-1:0] gnt_ch
);

    logic [NCH-1:0]  pend_q;
    logic [NCH-1:0]  link_vec;
    logic [NCH-1:0]  clr_vec;
    logic [CH_W-1:0] last_q;
    logic [CH_W-1:0] idx;

    always_comb begin
        link_vec = '0;
        clr_vec  = '0;
        if (link_valid) begin
            link_vec[link_ch] = 1'b1;
        end
        if (take) begin
            clr_vec[gnt_ch] = 1'b1;
        end
    end

    always_comb begin
        gnt_valid = 1'b0;
        gnt_ch    = '0;
        idx       = '0;
        if (!rr_mode) begin
            for (int i = 0; i < NCH; i++) begin
                if (pend_q[i] && !gnt_valid) begin
                    gnt_valid = 1'b1;
                    gnt_ch    = CH_W'(i);
                end
            end
        end else begin
            for (int k = 0; k < NCH; k++) begin
                idx = last_q + CH_W'(k + 1);
                if (pend_q[idx] && !gnt_valid) begin
                    gnt_valid = 1'b1;
                    gnt_ch    = idx;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            last_q <= CH_W'(NCH - 1);
        end else begin
            pend_q <= (pend_q & ~clr_vec) | start | link_vec;
            if (take) begin
                last_q <= gnt_ch;
            end
        end
    end

endmodule

// File: rtl/lld_engine.sv
module lld_engine
    import lld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_valid,
    input  logic [CH_W-1:0]   gnt_ch,
    output logic              take,
    output logic [CH_W-1:0]   ch_o,
    output eng_state_t        st_o,
    input  desc_t             desc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_saddr,
    output logic [ADDR_W-1:0] wb_daddr,
    output logic [CNT_W-1:0]  wb_citer,
    output logic              done_set,
    output logic              link_valid,
    output logic [CH_W-1:0]   link_ch
);

    eng_state_t        state, state_n;
    logic [CH_W-1:0]   ch_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [WRD_W-1:0]  words_q;
    logic [DATA_W-1:0] data_q;
    logic              last_loop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    assign last_loop = (desc.citer <= CNT_W'(1));

    // next state and outputs
    always_comb begin
        state_n    = state;
        take       = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = src_q;
        wb_en      = 1'b0;
        wb_saddr   = src_q;
        wb_daddr   = dst_q;
        wb_citer   = desc.citer - CNT_W'(1);
        done_set   = 1'b0;
        link_valid = 1'b0;
        link_ch    = desc.mlink_ch;
        unique case (state)
            ST_IDLE: begin
                if (gnt_valid) begin
                    take    = 1'b1;
                    state_n = ST_LOAD;
                end
            end
            ST_LOAD: begin
                state_n = (desc.nwords == '0) ? ST_FINISH : ST_READ;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
                if (mem_ready) begin
                    state_n = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                if (mem_ready) begin
                    state_n = (words_q == WRD_W'(1)) ? ST_FINISH : ST_READ;
                end
            end
            ST_FINISH: begin
                wb_en   = 1'b1;
                state_n = ST_IDLE;
                if (last_loop) begin
                    wb_saddr   = src_q + desc.scorr;
                    wb_daddr   = dst_q + desc.dcorr;
                    wb_citer   = desc.biter;
                    done_set   = 1'b1;
                    link_valid = desc.elink_en;
                    link_ch    = desc.elink_ch;
                end else begin
                    link_valid = desc.mlink_en;
                    link_ch    = desc.mlink_ch;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // working registers of the running inner loop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            words_q <= '0;
            data_q  <= '0;
        end else begin
            if (state == ST_IDLE && gnt_valid) begin
                ch_q <= gnt_ch;
            end
            if (state == ST_LOAD) begin
                src_q   <= desc.saddr;
                dst_q   <= desc.daddr;
                words_q <= desc.nwords;
            end
            if (state == ST_READ && mem_ready) begin
                data_q <= mem_rdata;
                src_q  <= src_q + sext_step(desc.sstep);
            end
            if (state == ST_WRITE && mem_ready) begin
                dst_q   <= dst_q + sext_step(desc.dstep);
                words_q <= words_q - WRD_W'(1);
            end
        end
    end

    assign mem_wdata = data_q;
    assign ch_o      = ch_q;
    assign st_o      = state;

endmodule

// File: rtl/lld_dma.sv
module lld_dma
    import lld_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [NCH-1:0]    start,
    input  logic              rr_mode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [NCH-1:0]    done,
    output logic [NCH-1:0]    irq
);

    eng_state_t        eng_state;
    logic [CH_W-1:0]   eng_ch;
    desc_t             cur_desc;
    logic              gnt_valid;
    logic [CH_W-1:0]   gnt_ch;
    logic              take;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_saddr;
    logic [ADDR_W-1:0] wb_daddr;
    logic [CNT_W-1:0]  wb_citer;
    logic              done_set;
    logic              link_valid;
    logic [CH_W-1:0]   link_ch;

    lld_desc_bank #(.NCH(NCH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_ch     (eng_ch),
        .rd_desc   (cur_desc),
        .wb_en     (wb_en),
        .wb_saddr  (wb_saddr),
        .wb_daddr  (wb_daddr),
        .wb_citer  (wb_citer),
        .done_set  (done_set),
        .start     (start),
        .done      (done),
        .irq       (irq)
    );

    lld_arbiter #(.NCH(NCH)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .link_valid (link_valid),
        .link_ch    (link_ch),
        .rr_mode    (rr_mode),
        .take       (take),
        .gnt_valid  (gnt_valid),
        .gnt_ch     (gnt_ch)
    );

    lld_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_valid  (gnt_valid),
        .gnt_ch     (gnt_ch),
        .take       (take),
        .ch_o       (eng_ch),
        .st_o       (eng_state),
        .desc       (cur_desc),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .wb_en      (wb_en),
        .wb_saddr   (wb_saddr),
        .wb_daddr   (wb_daddr),
        .wb_citer   (wb_citer),
        .done_set   (done_set),
        .link_valid (link_valid),
        .link_ch    (link_ch)
    );

endmodule

// File: rtl/lld_dma_chk.sv
module lld_dma_chk
    import lld_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [NCH-1:0]    done,
    input eng_state_t        eng_state,
    input logic [CH_W-1:0]   eng_ch
);

    // R14
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R2
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=> (mem_req && mem_we));

    // R12
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_WRITE || eng_state == ST_FINISH) |-> $stable(eng_ch));

    // R13
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & ~$past(done)) != '0) |-> ($past(eng_state) == ST_FINISH));

    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(done & ~$past(done)) <= 1);

    // R12
    load_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_LOAD) |-> ($past(eng_state) == ST_IDLE));

endmodule

bind lld_dma lld_dma_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .eng_state (eng_state),
    .eng_ch    (eng_ch)
);

// File: tb/sim_lld_dma.sv
`timescale 1ns/1ps
module sim_lld_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] start = '0;
    logic        rr_mode = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] done, irq;

    logic [31:0] mem [0:1023];
    logic        log_we [0:511];
    logic [31:0] log_addr [0:511];
    int          log_n = 0;
    logic        bw_en = 1'b0;
    logic [9:0]  bw_idx = '0;
    logic [31:0] bw_data = '0;
    logic        stall_mode = 1'b0;
    logic [1:0]  stall_cnt = '0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    lld_dma u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .start(start),
        .rr_mode(rr_mode), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .irq(irq)
    );

    assign mem_ready = mem_req && (!stall_mode || stall_cnt == 2'd0);
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        stall_cnt <= (stall_cnt == 2'd2) ? 2'd0 : stall_cnt + 2'd1;
        if (bw_en) mem[bw_idx] <= bw_data;
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            log_we[log_n[8:0]]   <= mem_we;
            log_addr[log_n[8:0]] <= mem_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        bw_en = 1'b1; bw_idx = addr[11:2]; bw_data = data;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic cfg(input int ch, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] src, input logic [31:0] dst,
                         input logic [31:0] nbytes, input logic [31:0] major,
                         input logic [15:0] sst, input logic [15:0] dst_st,
                         input logic [31:0] sc, input logic [31:0] dc,
                         input logic [31:0] ctrl);
        cfg(ch, 3'd0, src);
        cfg(ch, 3'd1, dst);
        cfg(ch, 3'd2, nbytes);
        cfg(ch, 3'd3, major);
        cfg(ch, 3'd4, {dst_st, sst});
        cfg(ch, 3'd5, sc);
        cfg(ch, 3'd6, dc);
        cfg(ch, 3'd7, ctrl);
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        start = m;
        @(negedge clk);
        start = '0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 30) begin
            @(negedge clk);
            q = mem_req ? 0 : q + 1;
        end
    endtask

    function automatic int count_wr(input int base, input logic [31:0] lo);
        int n = 0;
        for (int i = base; i < log_n; i++)
            if (log_we[i] && log_addr[i] >= lo && log_addr[i] < lo + 32'h40) n++;
        return n;
    endfunction

    function automatic logic [31:0] nth_wr(input int base, input int k);
        int n = 0;
        for (int i = base; i < log_n; i++) begin
            if (log_we[i]) begin
                if (n == k) return log_addr[i];
                n++;
            end
        end
        return 32'hDEAD_DEAD;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 irq after reset", 32'(irq), 32'd0);
    endtask

    task automatic t_basic();
        int b;
        for (int i = 0; i < 4; i++) poke(32'h100 + 32'(i*4), 32'hA000_0000 + 32'(i));
        setup(3, 32'h100, 32'h8C0, 16, 1, 16'd4, 16'd4, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h1);
        b = log_n;
        pulse(16'h0008);
        wait_quiet();
        check("R3 access count", 32'(log_n - b), 32'd8);
        check("R2 first access is read", 32'(log_we[b]), 32'd0);
        check("R2 first read address", log_addr[b], 32'h100);
        check("R2 second access is write", 32'(log_we[b+1]), 32'd1);
        check("R2 first write address", log_addr[b+1], 32'h8C0);
        for (int i = 0; i < 4; i++)
            check("R2 copied word", mem[(32'h8C0 >> 2) + i], 32'hA000_0000 + 32'(i));
        check("R13 done[3]", 32'(done[3]), 32'd1);
        check("R13 irq[3] enabled", 32'(irq[3]), 32'd1);
    endtask

    task automatic t_steps();
        for (int i = 0; i < 6; i++) poke(32'h140 + 32'(i*4), 32'hB000_0000 + 32'(i));
        setup(2, 32'h140, 32'h88C, 12, 1, 16'd8, 16'hFFFC, 32'h0, 32'h0, 32'h0);
        pulse(16'h0004);
        wait_quiet();
        check("R4 stepped word 0", mem[32'h88C >> 2], 32'hB000_0000);
        check("R4 stepped word 1", mem[32'h888 >> 2], 32'hB000_0002);
        check("R4 stepped word 2", mem[32'h884 >> 2], 32'hB000_0004);
        check("R13 done[2]", 32'(done[2]), 32'd1);
        check("R13 irq[2] masked", 32'(irq[2]), 32'd0);
    endtask

    task automatic t_major();
        int b;
        for (int i = 0; i < 4; i++) poke(32'h200 + 32'(i*4), 32'hC000_0000 + 32'(i));
        setup(5, 32'h200, 32'h940, 4, 3, 16'd4, 16'd4, 32'hFFFF_FFF4, 32'hFFFF_FFF4, 32'h1);
        b = log_n;
        pulse(16'h0020);
        wait_quiet();
        check("R5 one inner loop per start", 32'(count_wr(b, 32'h940)), 32'd1);
        check("R5 not done after first", 32'(done[5]), 32'd0);
        pulse(16'h0020);
        wait_quiet();
        pulse(16'h0020);
        wait_quiet();
        check("R5 third write address", nth_wr(b, 2), 32'h948);
        check("R4 third word data", mem[32'h948 >> 2], 32'hC000_0002);
        check("R5 done after last", 32'(done[5]), 32'd1);
        pulse(16'h0020);
        wait_quiet();
        check("R6 reuse restarts at original dst", nth_wr(b, 3), 32'h940);
        check("R7 start clears done", 32'(done[5]), 32'd0);
    endtask

    task automatic t_links();
        int b;
        setup(1, 32'h300, 32'h840, 4, 2, 16'd4, 16'd4, 32'h0, 32'h0,
              32'h2 | (32'd6 << 4) | 32'h100 | (32'd7 << 12));
        setup(6, 32'h310, 32'h980, 4, 5, 16'd4, 16'd4, 32'h0, 32'h0, 32'h0);
        setup(7, 32'h320, 32'h9C0, 4, 1, 16'd4, 16'd4, 32'h0, 32'h0, 32'h0);
        b = log_n;
        pulse(16'h0002);
        wait_quiet();
        check("R8 minor link ran ch6", 32'(count_wr(b, 32'h980)), 32'd1);
        check("R9 no major link yet", 32'(count_wr(b, 32'h9C0)), 32'd0);
        check("R5 ch1 not done", 32'(done[1]), 32'd0);
        b = log_n;
        pulse(16'h0002);
        wait_quiet();
        check("R9 major link ran ch7", 32'(count_wr(b, 32'h9C0)), 32'd1);
        check("R8 minor link silent on last", 32'(count_wr(b, 32'h980)), 32'd0);
        check("R9 ch7 done", 32'(done[7]), 32'd1);
    endtask

    task automatic t_arbit();
        int b;
        rr_mode = 1'b0;
        setup(4,  32'h380, 32'h900, 4, 8, 16'd0, 16'd0, 32'h0, 32'h0, 32'h0);
        setup(9,  32'h380, 32'hA40, 4, 8, 16'd0, 16'd0, 32'h0, 32'h0, 32'h0);
        setup(12, 32'h380, 32'hB00, 4, 8, 16'd0, 16'd0, 32'h0, 32'h0, 32'h0);
        setup(10, 32'h380, 32'hA80, 4, 8, 16'd0, 16'd0, 32'h0, 32'h0, 32'h0);
        b = log_n;
        pulse(16'h1210);
        wait_quiet();
        check("R10 fixed first", nth_wr(b, 0), 32'h900);
        check("R10 fixed second", nth_wr(b, 1), 32'hA40);
        check("R10 fixed third", nth_wr(b, 2), 32'hB00);
        @(negedge clk);
        rr_mode = 1'b1;
        pulse(16'h0400);
        wait_quiet();
        b = log_n;
        pulse(16'h1210);
        wait_quiet();
        check("R11 round-robin first", nth_wr(b, 0), 32'hB00);
        check("R11 round-robin second", nth_wr(b, 1), 32'h900);
        check("R11 round-robin third", nth_wr(b, 2), 32'hA40);
        @(negedge clk);
        rr_mode = 1'b0;
    endtask

    task automatic t_merge();
        int b;
        setup(14, 32'h400, 32'hB80, 64, 1, 16'd4, 16'd4, 32'h0, 32'h0, 32'h0);
        setup(8,  32'h380, 32'hA00, 4, 4, 16'd0, 16'd0, 32'h0, 32'h0, 32'h0);
        b = log_n;
        pulse(16'h4000);
        repeat (3) @(negedge clk);
        pulse(16'h0100);
        repeat (2) @(negedge clk);
        pulse(16'h0100);
        wait_quiet();
        check("R12 long loop not preempted", 32'(count_wr(b, 32'hB80) - 0), 32'd16);
        check("R12 ch8 after the long loop", log_addr[b+32], 32'h380);
        check("R12 repeated start merged", 32'(count_wr(b, 32'hA00)), 32'd1);
    endtask

    task automatic t_zero();
        int b;
        setup(11, 32'h100, 32'hAC0, 0, 1, 16'd4, 16'd4, 32'h0, 32'h0, 32'h1);
        b = log_n;
        pulse(16'h0800);
        wait_quiet();
        check("R3 zero count no access", 32'(log_n - b), 32'd0);
        check("R3 zero count completes", 32'(done[11]), 32'd1);
        check("R13 irq[11]", 32'(irq[11]), 32'd1);
    endtask

    task automatic t_stall();
        int b;
        poke(32'h180, 32'hD000_0000);
        poke(32'h184, 32'hD000_0001);
        setup(13, 32'h180, 32'hB40, 8, 1, 16'd4, 16'd4, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        stall_mode = 1'b1;
        b = log_n;
        pulse(16'h2000);
        wait_quiet();
        check("R14 accepted accesses with waits", 32'(log_n - b), 32'd4);
        check("R14 word 0 with waits", mem[32'hB40 >> 2], 32'hD000_0000);
        check("R14 word 1 with waits", mem[32'hB44 >> 2], 32'hD000_0001);
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_steps();
        t_major();
        t_links();
        t_arbit();
        t_merge();
        t_zero();
        t_stall();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule